// File: doc/BRIEF.md
# Multi-Bank Tile Memory Unit

This block holds four independent tile memories. Threads use them as scratch storage laid out over a 32 by 32 grid. Each grid position stores one 64-bit entry, split into four 16-bit components. A request selects one memory by a fixed index and chooses one of two addressing styles. A local request uses the thread's own tile position, which the requester supplies with the request. A non-local request uses an explicit location and takes one extra cycle.

A write has a 4-bit per-component enable, and the components it leaves out keep their old contents. A read returns the complete 64-bit entry together with the tag of the request, and read responses leave the block in the order the requests were accepted.

The request side and the response side are both valid/ready streams. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` may depend on `req_local`. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While a response waits for `rsp_ready`, the response is held unchanged and `req_ready` stays low.

Top module: `tile_mem_unit`

## Requirements
- R1: After reset, `rsp_valid` is low, and with no response pending `req_ready` is high.
- R2: An accepted local read addresses the entry at `req_pos`, a linear index equal to row*32+column. Its response is valid in the cycle right after acceptance when `rsp_ready` is high.
- R3: An accepted non-local read addresses the entry at `req_loc`, which uses the same row*32+column encoding. Its response is valid two cycles after acceptance when `rsp_ready` is high.
- R4: The four memories, selected by `req_mem` values 0 to 3, are independent. A write to one memory leaves the same location in the other three memories unchanged.
- R5: Component k (x=0, y=1, z=2, w=3) occupies data bits [16k+15:16k] and is written only when `req_mask[3-k]` is 1, so x is controlled by the most significant mask bit. A component whose mask bit is 0 keeps its previous contents.
- R6: A read response carries the complete 64-bit entry and echoes the request's `req_tag` on `rsp_tag`.
- R7: Read responses come out in acceptance order. With no stall, the block accepts one request per cycle, including back-to-back non-local requests.
- R8: In the cycle right after a non-local request is accepted, a local request is held off (`req_ready` low) for exactly one cycle.
- R9: A read accepted in the cycle after a write to the same entry returns the newly written data.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_tag` and `rsp_data` stay stable and `req_ready` is low.
- R11: Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_local | input | 1 | 1 = address by thread position, 0 = explicit location |
| req_mem | input | 2 | Tile memory index |
| req_pos | input | 10 | Thread tile position (row*32+column) for local requests |
| req_loc | input | 10 | Explicit location (row*32+column) for non-local requests |
| req_mask | input | 4 | Component write enables, bit 3 = x |
| req_wdata | input | 64 | Write data |
| req_tag | input | 4 | Request tag |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response on this edge |
| rsp_tag | output | 4 | Tag of the answered read |
| rsp_data | output | 64 | Full 64-bit entry read |

## Verification
Two events can fall in the same cycle, and each must resolve correctly. First, a non-local request leaving its address stage can meet a new local request that wants the single memory port in that same cycle. Second, a write can be directly followed by a read of the same entry. The bench provokes the first case by driving a local read straight after a non-local read. It judges the case from the one-cycle hold-off on `req_ready` and from the order of the scoreboard. The bench provokes the second case with back-to-back write/read pairs in both addressing styles. A scoreboard model, updated at acceptance time, must show the freshly written components in the read.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  typedef enum logic {
    KIND_READ  = 1'b0,
    KIND_WRITE = 1'b1
  } kind_e;

  // Mask bit that enables component k: the first component (x) sits on the top bit.
  function automatic int unsigned mask_bit(input int unsigned lanes, input int unsigned k);
    return lanes - 1 - k;
  endfunction

endpackage

// File: rtl/tmu_issue.sv
module tmu_issue #(
  parameter int MEM_W  = 2,
  parameter int LOC_W  = 10,
  parameter int LANES  = 4,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_local,
  input  logic [MEM_W-1:0]  req_mem,
  input  logic [LOC_W-1:0]  req_pos,
  input  logic [LOC_W-1:0]  req_loc,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              iss_valid,
  output tmu_pkg::kind_e    iss_kind,
  output logic [MEM_W-1:0]  iss_mem,
  output logic [LOC_W-1:0]  iss_loc,
  output logic [LANES-1:0]  iss_mask,
  output logic [DATA_W-1:0] iss_wdata,
  output logic [TAG_W-1:0]  iss_tag
);

  // Address stage for non-local requests (adds one cycle of latency)
  logic              far_valid;
  tmu_pkg::kind_e    far_kind;
  logic [MEM_W-1:0]  far_mem;
  logic [LOC_W-1:0]  far_loc;
  logic [LANES-1:0]  far_mask;
  logic [DATA_W-1:0] far_wdata;
  logic [TAG_W-1:0]  far_tag;

  logic accept;
  logic port_busy;

  // A staged non-local request owns the memory port this cycle.
  assign port_busy = far_valid && req_local;
  assign req_ready = adv && !port_busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (far_valid) begin
      iss_valid = adv;
      iss_kind  = far_kind;
      iss_mem   = far_mem;
      iss_loc   = far_loc;
      iss_mask  = far_mask;
      iss_wdata = far_wdata;
      iss_tag   = far_tag;
    end else begin
      iss_valid = accept && req_local;
      iss_kind  = req_write ? tmu_pkg::KIND_WRITE : tmu_pkg::KIND_READ;
      iss_mem   = req_mem;
      iss_loc   = req_pos;
      iss_mask  = req_mask;
      iss_wdata = req_wdata;
      iss_tag   = req_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      far_valid <= 1'b0;
    end else if (adv) begin
      far_valid <= accept && !req_local;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !req_local) begin
      far_kind  <= req_write ? tmu_pkg::KIND_WRITE : tmu_pkg::KIND_READ;
      far_mem   <= req_mem;
      far_loc   <= req_loc;
      far_mask  <= req_mask;
      far_wdata <= req_wdata;
      far_tag   <= req_tag;
    end
  end

endmodule

// File: rtl/tmu_bank.sv
module tmu_bank #(
  parameter int DEPTH  = 1024,
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int LOC_W  = $clog2(DEPTH),
  parameter int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LOC_W-1:0]  addr,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned MB = tmu_pkg::mask_bit(LANES, k);
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && mask[MB]) begin
        store[addr] <= wdata[k*LANE_W +: LANE_W];
      end
      if (rd_en) begin
        rd_data[k*LANE_W +: LANE_W] <= store[addr];
      end
    end
  end

endmodule

// File: rtl/tile_mem_unit.sv
module tile_mem_unit #(
  parameter int NUM_MEMS = 4,
  parameter int ROWS     = 32,
  parameter int COLS     = 32,
  parameter int LANE_W   = 16,
  parameter int LANES    = 4,
  parameter int TAG_W    = 4,
  localparam int DEPTH   = ROWS * COLS,
  localparam int LOC_W   = $clog2(DEPTH),
  localparam int MEM_W   = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1,
  localparam int DATA_W  = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_local,
  input  logic [MEM_W-1:0]  req_mem,
  input  logic [LOC_W-1:0]  req_pos,
  input  logic [LOC_W-1:0]  req_loc,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data
);

  logic              adv;
  logic              iss_valid;
  tmu_pkg::kind_e    iss_kind;
  logic [MEM_W-1:0]  iss_mem;
  logic [LOC_W-1:0]  iss_loc;
  logic [LANES-1:0]  iss_mask;
  logic [DATA_W-1:0] iss_wdata;
  logic [TAG_W-1:0]  iss_tag;
  logic              iss_read;
  logic [MEM_W-1:0]  sel_q;
  logic [DATA_W-1:0] bank_q [NUM_MEMS];

  // The whole pipeline moves only when the response slot is free or draining.
  assign adv      = !rsp_valid || rsp_ready;
  assign iss_read = iss_valid && (iss_kind == tmu_pkg::KIND_READ);

  tmu_issue #(
    .MEM_W (MEM_W),
    .LOC_W (LOC_W),
    .LANES (LANES),
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
  ) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_local(req_local),
    .req_mem  (req_mem),
    .req_pos  (req_pos),
    .req_loc  (req_loc),
    .req_mask (req_mask),
    .req_wdata(req_wdata),
    .req_tag  (req_tag),
    .iss_valid(iss_valid),
    .iss_kind (iss_kind),
    .iss_mem  (iss_mem),
    .iss_loc  (iss_loc),
    .iss_mask (iss_mask),
    .iss_wdata(iss_wdata),
    .iss_tag  (iss_tag)
  );

  for (genvar b = 0; b < NUM_MEMS; b++) begin : g_mem
    logic hit;
    assign hit = iss_valid && (iss_mem == MEM_W'(b));

    tmu_bank #(
      .DEPTH (DEPTH),
      .LANE_W(LANE_W),
      .LANES (LANES),
      .LOC_W (LOC_W),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk    (clk),
      .wr_en  (hit && (iss_kind == tmu_pkg::KIND_WRITE)),
      .rd_en  (hit && (iss_kind == tmu_pkg::KIND_READ)),
      .addr   (iss_loc),
      .mask   (iss_mask),
      .wdata  (iss_wdata),
      .rd_data(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (adv) begin
      rsp_valid <= iss_read;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && iss_read) begin
      rsp_tag <= iss_tag;
      sel_q   <= iss_mem;
    end
  end

  assign rsp_data = bank_q[sel_q];

endmodule

// File: rtl/tmu_checker.sv
module tmu_checker #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_local,
  input logic [TAG_W-1:0]  req_tag,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [TAG_W-1:0]  rsp_tag,
  input logic [DATA_W-1:0] rsp_data
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R2
  local_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_local)
      |=> (rsp_valid && rsp_tag == $past(req_tag)));

  // R8
  local_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_local) |=> !(req_valid && req_local && req_ready));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_data)));

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind tile_mem_unit tmu_checker #(
  .TAG_W (TAG_W),
  .DATA_W(DATA_W)
) i_tmu_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_local(req_local),
  .req_tag  (req_tag),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_tag  (rsp_tag),
  .rsp_data (rsp_data)
);

// File: tb/test_tile_mem_unit.sv
`timescale 1ns/1ps
module test_tile_mem_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_local = 1'b0;
  logic [1:0]  req_mem = '0;
  logic [9:0]  req_pos = '0;
  logic [9:0]  req_loc = '0;
  logic [3:0]  req_mask = '0;
  logic [63:0] req_wdata = '0;
  logic [3:0]  req_tag = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [3:0]  rsp_tag;
  logic [63:0] rsp_data;

  always #2 clk = ~clk;

  tile_mem_unit i_tile_mem_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_local(req_local), .req_mem(req_mem), .req_pos(req_pos), .req_loc(req_loc),
    .req_mask(req_mask), .req_wdata(req_wdata), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit lat_on = 1'b1;
  bit bp_on  = 1'b0;
  int tagc   = 0;

  logic [63:0] model [4][1024];
  logic [63:0] exp_data_q [$];
  logic [3:0]  exp_tag_q  [$];
  int          exp_lat_q  [$];
  int          exp_acc_q  [$];
  string       exp_req_q  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic logic [63:0] pat(input int m, input int a, input int salt);
    return {8'(m), 8'(salt), 16'(a), 16'(a * 7 + salt), 16'(m * 311 + a)};
  endfunction

  // Driver: holds the request until accepted; updates the model and scoreboard.
  task automatic issue(input bit wr, input bit loc_mode, input int m, input int addr,
                       input logic [3:0] mask, input logic [63:0] d, input string req,
                       output int waits);
    int a;
    waits = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_local = loc_mode;
    req_mem   = 2'(m);
    req_pos   = loc_mode ? 10'(addr) : 10'(1023 - addr);
    req_loc   = loc_mode ? 10'(1023 - addr) : 10'(addr);
    req_mask  = mask;
    req_wdata = d;
    req_tag   = 4'(tagc);
    #1;
    while (!req_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    a = addr;
    if (wr) begin
      for (int k = 0; k < 4; k++)
        if (mask[3 - k]) model[m][a][16*k +: 16] = d[16*k +: 16];
    end else begin
      exp_data_q.push_back(model[m][a]);
      exp_tag_q.push_back(4'(tagc));
      exp_lat_q.push_back(lat_on ? (loc_mode ? 1 : 2) : -1);
      exp_acc_q.push_back(cyc);
      exp_req_q.push_back(req);
    end
    tagc++;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    int t = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_data_q.size() != 0 && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(exp_data_q.size() == 0, "R7", "outstanding reads", 64'(exp_data_q.size()), 64'd0);
  endtask

  // Monitor: pops the scoreboard as responses transfer.
  logic [3:0]  held_tag;
  logic [63:0] held_data;
  bit          was_stalled = 1'b0;
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (was_stalled) begin
        chk(rsp_valid && rsp_tag == held_tag && rsp_data == held_data, "R10",
            "held response", rsp_data, held_data);
      end
      was_stalled = 1'b0;
      if (rsp_valid && !rsp_ready) begin
        chk(!req_ready, "R10", "req_ready during stall", 64'(req_ready), 64'd0);
        held_tag    = rsp_tag;
        held_data   = rsp_data;
        was_stalled = 1'b1;
      end else if (rsp_valid && rsp_ready) begin
        if (exp_data_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected response", rsp_data, 64'd0);
        end else begin
          logic [63:0] ed;
          logic [3:0]  et;
          int el;
          int ea;
          string er;
          ed = exp_data_q.pop_front();
          et = exp_tag_q.pop_front();
          el = exp_lat_q.pop_front();
          ea = exp_acc_q.pop_front();
          er = exp_req_q.pop_front();
          chk(rsp_data === ed, er, "read data", rsp_data, ed);
          chk(rsp_tag === et, "R6", "response tag", 64'(rsp_tag), 64'(et));
          if (el > 0)
            chk(cyc - ea == el, el == 1 ? "R2" : "R3", "latency", 64'(cyc - ea), 64'(el));
        end
      end
    end
  end

  // Back-pressure pattern on the response port.
  always begin
    @(negedge clk);
    rsp_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
  end

  initial begin
    #80000;
    fails++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int w;
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1
    chk(!rsp_valid, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready, "R1", "req_ready when idle", 64'(req_ready), 64'd1);

    // Fill test positions in all four memories (R4 setup), local and non-local writes.
    p = 5 * 32 + 7;
    for (int m = 0; m < 4; m++) begin
      issue(1, 1, m, p, 4'b1111, pat(m, p, 1), "R4", w);
      issue(1, 0, m, 1023, 4'b1111, pat(m, 1023, 2), "R4", w);
      issue(1, 0, m, 0, 4'b1111, pat(m, 0, 3), "R4", w);
    end
    // R11: writes alone give no response
    idle(6);
    chk(!rsp_valid && exp_data_q.size() == 0, "R11", "no response after writes",
        64'(rsp_valid), 64'd0);

    // R2/R6: local reads from each memory
    for (int m = 0; m < 4; m++) issue(0, 1, m, p, 4'b0000, 64'd0, "R2", w);
    drain();
    // R3: non-local reads
    for (int m = 0; m < 4; m++) begin
      issue(0, 0, m, 1023, 4'b0000, 64'd0, "R3", w);
      chk(w == 0, "R7", "back-to-back non-local waits", 64'(w), 64'd0);
    end
    drain();

    // R5: masked writes, x and z only, then y only
    issue(1, 1, 1, p, 4'b1010, 64'hAAAA_BBBB_CCCC_DDDD, "R5", w);
    idle(2);
    issue(0, 0, 1, p, 4'b0000, 64'd0, "R5", w);
    issue(1, 0, 1, 0, 4'b0100, 64'h1234_5678_9ABC_DEF0, "R5", w);
    idle(2);
    issue(0, 1, 1, 0, 4'b0000, 64'd0, "R5", w);
    drain();

    // R4: write memory 2, others unchanged at the same location
    issue(1, 1, 2, 1023, 4'b1111, 64'hFEED_FACE_0BAD_CAFE, "R4", w);
    for (int m = 0; m < 4; m++) issue(0, 0, m, 1023, 4'b0000, 64'd0, "R4", w);
    drain();

    // R9: read right after write, both addressing styles
    issue(1, 1, 3, p, 4'b0011, 64'h0101_0202_0303_0404, "R9", w);
    issue(0, 1, 3, p, 4'b0000, 64'd0, "R9", w);
    chk(w == 0, "R7", "local read after local write waits", 64'(w), 64'd0);
    issue(1, 0, 0, 0, 4'b1001, 64'h5555_6666_7777_8888, "R9", w);
    issue(0, 0, 0, 0, 4'b0000, 64'd0, "R9", w);
    drain();

    // R8: local request straight after a non-local one
    issue(0, 0, 2, 1023, 4'b0000, 64'd0, "R8", w);
    issue(0, 1, 0, p, 4'b0000, 64'd0, "R8", w);
    chk(w == 1, "R8", "local after non-local waits", 64'(w), 64'd1);
    issue(1, 0, 3, 0, 4'b1111, 64'hDEAD_0000_BEEF_1111, "R8", w);
    issue(1, 1, 3, 0, 4'b0001, 64'h0000_0000_0000_2222, "R8", w);
    chk(w == 1, "R8", "local write after non-local waits", 64'(w), 64'd1);
    issue(0, 1, 3, 0, 4'b0000, 64'd0, "R9", w);
    drain();

    // R10/R7: back-pressure with a mixed stream
    lat_on = 1'b0;
    bp_on  = 1'b1;
    for (int i = 0; i < 24; i++)
      issue(0, (i % 3) != 1, i % 4, (i % 2) ? p : 1023, 4'b0000, 64'd0, "R7", w);
    drain();
    bp_on = 1'b0;
    idle(4);

    summary();
    $finish;
  end

endmodule